// File: doc/BRIEF.md
# Stuck-High Line Detector

This block watches one digital input line and drives an enable flag for a downstream combining gate. While the line toggles normally, or sits low, the enable stays high. If the line stays high without a break for longer than a set number of clock cycles, the block treats it as stuck or floating and drops the enable. This stops a disconnected input with inverted logic from holding an OR gate high and hiding pulses on the other inputs of that gate.

The line is brought into the clock domain through a two-flop synchronizer. A saturating counter then measures how long the synchronized line has been high. The enable comes back in the first cycle in which the synchronized line reads low, for example when a cable is plugged in. The counter clears one edge after that.

The limit `MAX_COUNT` is a parameter, and the counter width is derived from it. The default of 12499 gives about 100 µs of high time at 125 MHz.

Top module: `line_stuck_guard`

## Requirements
- R1: While reset is asserted, and after it is released with the line low, `enable_o` is high, whatever level the line had during reset.
- R2: The line reaches the decision logic through two flip-flop stages. After the first rising edge that samples the line low following a stuck period, `enable_o` is still low.
- R3: If the line is sampled high at `MAX_COUNT`+1 consecutive rising edges, `enable_o` is low right after the next rising edge.
- R4: A high run of `MAX_COUNT` or fewer consecutive samples never drops `enable_o`.
- R5: Once the line is sampled low, `enable_o` is high again right after the following rising edge, in the same cycle in which the synchronized line is low.
- R6: The high-time counter saturates at `MAX_COUNT` and does not wrap. `enable_o` stays low for as long as the line stays high, including runs much longer than `MAX_COUNT`.
- R7: A single low sample clears the measured high time. A new high run must again reach `MAX_COUNT`+1 samples before `enable_o` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Monitored line, asynchronous to `clk` |
| enable_o | output | 1 | High while the line is not considered stuck high |

## Verification
Counting from the rising edge that first samples a high line as sample 1, `enable_o` is due low right after the edge that follows sample `MAX_COUNT`+1. After the first low sample, `enable_o` is due high one edge later, and not at the edge that took the sample. The bench drives the line at the falling edge and records each driven value at the next rising edge. It keeps its own run length of consecutive high samples, which at each edge gives the enable expected after the following edge. It compares `enable_o` at every falling edge, so every check lands half a period after the register update it depends on.

// File: rtl/stuck_guard_pkg.sv
`timescale 1ns/1ps
package stuck_guard_pkg;

  // Bits needed to hold values 0..lim inclusive.
  function automatic int unsigned cnt_width(input int unsigned lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

  // One step of the saturating high-time count.
  function automatic int unsigned count_step(input int unsigned cur,
                                             input logic        hi,
                                             input int unsigned lim);
    if (!hi)        return 0;
    if (cur >= lim) return lim;
    return cur + 1;
  endfunction

endpackage

// File: rtl/sg_sync.sv
`timescale 1ns/1ps
module sg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  assign stage_d = {stage_q[STAGES-2:0], d_i};

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= 1'b0;
      else        stage_q[i] <= stage_d[i];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sg_high_counter.sv
`timescale 1ns/1ps
module sg_high_counter
  import stuck_guard_pkg::*;
#(
  parameter int unsigned MAX_COUNT = 12499,
  localparam int unsigned CNT_W    = cnt_width(MAX_COUNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_limit_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_COUNT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = CNT_W'(count_step(32'(cnt_q), hi_i, MAX_COUNT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign at_limit_o = (cnt_q == LIMIT);
endmodule

// File: rtl/sg_enable_gate.sv
`timescale 1ns/1ps
module sg_enable_gate (
  input  logic line_sync_i,
  input  logic at_limit_i,
  output logic enable_o
);
  // A low synchronized line restores the enable before the counter clears.
  assign enable_o = ~line_sync_i | ~at_limit_i;
endmodule

// File: rtl/line_stuck_guard.sv
`timescale 1ns/1ps
module line_stuck_guard
  import stuck_guard_pkg::*;
#(
  parameter int unsigned MAX_COUNT   = 12499,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = cnt_width(MAX_COUNT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic enable_o
);
  // Internal events, named for the checker.
  logic             line_sync;
  logic [CNT_W-1:0] hi_cnt;
  logic             at_limit;

  sg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (line_i),
    .q_o   (line_sync)
  );

  sg_high_counter #(.MAX_COUNT(MAX_COUNT)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .hi_i       (line_sync),
    .cnt_o      (hi_cnt),
    .at_limit_o (at_limit)
  );

  sg_enable_gate u_gate (
    .line_sync_i (line_sync),
    .at_limit_i  (at_limit),
    .enable_o    (enable_o)
  );
endmodule

// File: rtl/stuck_guard_checker.sv
`timescale 1ns/1ps
module stuck_guard_checker
  import stuck_guard_pkg::*;
#(
  parameter int unsigned MAX_COUNT = 12499,
  localparam int unsigned CNT_W    = cnt_width(MAX_COUNT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_i,
  input logic             enable_o,
  input logic             line_sync,
  input logic [CNT_W-1:0] hi_cnt,
  input logic             at_limit
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_COUNT);

  // R1: enable held high under reset
  assert_reset_enable_R1: assert property (@(posedge clk) !rst_n |-> enable_o);

  // R3: counter advances by one while synchronized line high and below limit
  assert_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_sync && !at_limit) |=> (hi_cnt == $past(hi_cnt) + 1'b1));

  // R3: enable only ever low with counter at its limit
  assert_low_needs_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_o |-> (hi_cnt == LIMIT));

  // R5: a low sample two edges back forces the enable high
  assert_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line_i, 2) == 1'b0) |-> enable_o);

  // R6: counter holds at limit, no wrap
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_limit && line_sync) |=> at_limit);

  // R7: low synchronized line clears the count
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !line_sync |=> (hi_cnt == '0));
endmodule

bind line_stuck_guard stuck_guard_checker #(.MAX_COUNT(MAX_COUNT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_i    (line_i),
  .enable_o  (enable_o),
  .line_sync (line_sync),
  .hi_cnt    (hi_cnt),
  .at_limit  (at_limit)
);

// File: tb/tb_line_stuck_guard.sv
`timescale 1ns/1ps
module tb_line_stuck_guard;
  localparam int unsigned LIM = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line = 1'b0;
  logic enable;

  int checks = 0;
  int errors = 0;
  int run    = 0;   // consecutive high samples up to the last edge
  bit done   = 1'b0;

  always #2 clk = ~clk;

  line_stuck_guard #(.MAX_COUNT(LIM)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (line),
    .enable_o (enable)
  );

  // Expected enable after an edge, from the run ending one edge earlier.
  function automatic logic model_enable(input int prev_run);
    return !(prev_run >= int'(LIM) + 1);
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s enable actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one sample at the falling edge, check after the following edge.
  task automatic cycle(input logic v, input string tag);
    logic exp;
    line = v;
    @(posedge clk);
    exp = model_enable(run);
    run = v ? run + 1 : 0;
    @(negedge clk);
    check(enable, exp, tag);
  endtask

  task automatic hold(input logic v, input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(v, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: line high during reset does not disturb the enable
    line = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(enable, 1'b1, "R1");
    end
    line = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    run = 0;
    hold(1'b0, 4, "R1");

    // R4: exactly LIM high samples keep enable up
    hold(1'b1, LIM, "R4");
    hold(1'b0, 3, "R4");
    hold(1'b1, 1, "R4");
    hold(1'b0, 2, "R4");

    // R3: LIM+1 samples drop it on the following edge
    hold(1'b1, LIM + 1, "R3");
    cycle(1'b1, "R3");
    // R6: long hold, well past counter wrap width
    hold(1'b1, 3 * LIM, "R6");
    // R2 then R5: first low sample keeps it low, next edge restores
    cycle(1'b0, "R2");
    cycle(1'b0, "R5");
    hold(1'b0, 2, "R5");

    // R7: one low sample between two near-limit runs
    hold(1'b1, LIM, "R7");
    cycle(1'b0, "R7");
    hold(1'b1, LIM, "R7");
    cycle(1'b0, "R7");
    cycle(1'b0, "R7");
    // R7: drop, single low gap, then must wait a full run again
    hold(1'b1, LIM + 4, "R7");
    cycle(1'b0, "R7");
    hold(1'b1, LIM, "R7");
    hold(1'b1, 3, "R7");
    hold(1'b0, 3, "R7");

    // Random runs around the threshold
    for (int k = 0; k < 80; k++) begin
      int len;
      len = 1 + int'($urandom_range(2 * LIM + 6));
      hold(1'b1, len, "R3");
      hold(1'b0, 1 + int'($urandom_range(4)), "R5");
    end
    // Random per-sample noise
    for (int k = 0; k < 400; k++) cycle(logic'($urandom_range(1)), "R4");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule